// File: doc/BRIEF.md
# Counter-Flow Flush Recovery Controller

This controller handles timing errors in a five-stage in-order pipeline without stalling the whole pipeline. It keeps a valid bit and a program counter for the instruction held in each stage register. Registers 0 to NSTG-2 each have an error input. The register that feeds writeback is a stabilizer stage, so it has no error input.

When a valid stage register reports an error, the controller does four things. It keeps the failing instruction in that register for one more cycle, so the corrected shadow value can be injected. It turns the slot behind that register into a bubble, and the bubble then travels on to writeback as an empty slot. It starts a flush token that carries the failing stage number. The token walks back toward fetch one stage per cycle, clearing the younger instructions it reaches. When the token arrives at stage 0, fetch restarts at the instruction that follows the failing one.

Older instructions in the stages after the failing one keep moving during recovery. The error inputs are expected to come from the error flags of the stage registers.

Top module: `cf_recovery_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, every stage becomes empty, the flush token goes idle, inject_o becomes zero, and fetch_pc_o becomes RESET_PC.
- R2: In a cycle with no accepted error and no live token, stage 0 takes fetch_pc_o with its valid bit set, fetch_pc_o advances by STEP, and every other stage takes the contents of the stage before it. Writeback is stage NSTG-1.
- R3: When err_i bit k is accepted, then in the next cycle stage k still holds the same instruction, stage k+1 is empty, and inject_o has only bit k set. inject_o returns to zero one cycle later unless another error is accepted.
- R4: An empty slot moves downstream one stage per cycle, like an instruction, and reaches writeback with wb_vld_o low.
- R5: In the cycle after an error at stage k is accepted, flush_vld_o is high, flush_id_o equals k and flush_pos_o equals k. While no new error is accepted, flush_pos_o then decreases by one each cycle until it reaches 0.
- R6: While the token is at position p, stages above p keep advancing and stage p takes a bubble. Stage p-1 is cleared at that edge. Stages below p-1 hold their contents, and fetch_pc_o does not change.
- R7: In the cycle when the token is at position 0, restart_o is high and restart_pc_o equals the failing instruction's PC plus STEP. If no new error is accepted in that cycle, then in the next cycle flush_vld_o is low and fetch_pc_o equals restart_pc_o.
- R8: When several eligible errors arrive in the same cycle, the one with the highest stage number (the oldest instruction) is the one accepted.
- R9: An error is ignored if its stage is empty, or if its stage is below the position of a live token. An ignored error leaves the token and the stage contents as if it had not occurred.
- R10: An eligible error that arrives while a token is live, including in the cycle when the token is at position 0, starts a new recovery from that stage. The fetch redirect for the old token does not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_i | input | NSTG-1 | Error flag for each checked stage register |
| stage_vld_o | output | NSTG | Valid bit for each stage register (low means bubble) |
| inject_o | output | NSTG-1 | One-hot shadow-restore strobe, high in the cycle after an error |
| flush_vld_o | output | 1 | Flush token is live |
| flush_id_o | output | IDW | Stage number carried by the token |
| flush_pos_o | output | IDW | Stage the token currently sits at |
| restart_o | output | 1 | Token has reached the front of the pipeline |
| restart_pc_o | output | PCW | Address fetch resumes from |
| fetch_pc_o | output | PCW | Next fetch address |
| wb_vld_o | output | 1 | Writeback slot holds a valid instruction |
| wb_pc_o | output | PCW | PC of the instruction at writeback |

## Verification
Two functions can fall in the same cycle: accepting a fresh error and finishing an earlier token's walk. The sharpest case is an error on the re-injected instruction in the cycle its token sits at position 0. In that case the new catch must win, and fetch must not be redirected. A directed sequence sets this up by catching at stage 1 and then raising stage 2's error one cycle later. The result is judged on flush_id_o, flush_pos_o and fetch_pc_o against a cycle-level reference model in the bench. Simultaneous multi-stage errors and random error bursts during token walks are judged against the same model.

// File: rtl/cfr_pkg.sv
// Shared definitions for the counter-flow recovery controller.
// Assumes: one action is chosen per cycle for the whole pipeline.
package cfr_pkg;

    // Per-cycle pipeline action
    typedef enum logic [1:0] {
        ACT_RUN   = 2'd0,   // normal advance with fetch
        ACT_CATCH = 2'd1,   // error accepted this cycle
        ACT_WALK  = 2'd2    // flush token stepping back
    } act_e;

endpackage

// File: rtl/cfr_fault_pick.sv
// Picks the error to accept this cycle.
// Assumes: err_i bit g belongs to stage register g; the last stage has no
// error input. An error is eligible only if its stage is valid and, while a
// token is live, the stage is at or above the token. The highest eligible
// stage (oldest instruction) wins.
module cfr_fault_pick #(
    parameter int NSTG = 5,
    parameter int IDW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTG-2:0] err_i,
    input  logic [NSTG-1:0] vld_i,
    input  logic            live_i,
    input  logic [IDW-1:0]  pos_i,
    output logic            hit_o,
    output logic [IDW-1:0]  idx_o
);

    logic [NSTG-2:0] elig;

    // Eligibility mask, one bit per checked stage
    for (genvar g = 0; g < NSTG-1; g++) begin : g_elig
        assign elig[g] = err_i[g] & vld_i[g] & (~live_i | (IDW'(g) >= pos_i));
    end

    // Highest eligible stage wins
    always_comb begin
        hit_o = |elig;
        idx_o = '0;
        for (int j = 0; j < NSTG-1; j++) begin
            if (elig[j]) idx_o = IDW'(j);
        end
    end

    // R9
    accepted_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (err_i[idx_o] && vld_i[idx_o]));

    // R9
    not_below_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && live_i) |-> (idx_o >= pos_i));

endmodule

// File: rtl/cfr_flush_train.sv
// Flush token state and the per-cycle action decision.
// Assumes: hit_i/cidx_i come from the fault picker and fail_pc_i is the PC
// held in stage cidx_i. The token walks back one stage per cycle. At
// position 0 it redirects fetch unless a new error is accepted.
module cfr_flush_train
    import cfr_pkg::*;
#(
    parameter int             NSTG = 5,
    parameter int             PCW  = 16,
    parameter int             IDW  = 3,
    parameter logic [PCW-1:0] STEP = 'd4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_i,
    input  logic [IDW-1:0]  cidx_i,
    input  logic [PCW-1:0]  fail_pc_i,
    output act_e            act_o,
    output logic            live_o,
    output logic [IDW-1:0]  pos_o,
    output logic [IDW-1:0]  fid_o,
    output logic [PCW-1:0]  rpc_o,
    output logic [NSTG-2:0] inject_o,
    output logic            restart_o
);

    localparam logic [NSTG-2:0] INJ_ONE = {{(NSTG-2){1'b0}}, 1'b1};

    logic            live_q;
    logic [IDW-1:0]  pos_q;
    logic [IDW-1:0]  fid_q;
    logic [PCW-1:0]  rpc_q;
    logic [NSTG-2:0] inj_q;

    // Choose this cycle's action: a catch beats the walk, the walk beats run
    always_comb begin
        if (hit_i)       act_o = ACT_CATCH;
        else if (live_q) act_o = ACT_WALK;
        else             act_o = ACT_RUN;
    end

    // Token, restart address and inject strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            pos_q  <= '0;
            fid_q  <= '0;
            rpc_q  <= '0;
            inj_q  <= '0;
        end else begin
            unique case (act_o)
                ACT_CATCH: begin
                    live_q <= 1'b1;
                    pos_q  <= cidx_i;
                    fid_q  <= cidx_i;
                    rpc_q  <= fail_pc_i + STEP;
                    inj_q  <= INJ_ONE << cidx_i;
                end
                ACT_WALK: begin
                    inj_q <= '0;
                    if (pos_q == '0) live_q <= 1'b0;
                    else             pos_q  <= pos_q - 1'b1;
                end
                default: begin
                    inj_q <= '0;
                end
            endcase
        end
    end

    assign live_o    = live_q;
    assign pos_o     = pos_q;
    assign fid_o     = fid_q;
    assign rpc_o     = rpc_q;
    assign inject_o  = inj_q;
    assign restart_o = live_q && (pos_q == '0);

    // R3
    inject_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inj_q));

    // R3
    inject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|inj_q && !hit_i) |=> (inj_q == '0));

    // R5
    token_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> (live_q && fid_q == $past(cidx_i) && pos_q == $past(cidx_i)));

    // R5
    token_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !hit_i && pos_q != '0) |=> (live_q && pos_q == $past(pos_q) - 1'b1));

    // R7
    token_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o && !hit_i) |=> !live_q);

endmodule

// File: rtl/cfr_slot_track.sv
// Valid bit and PC for each stage register, plus the fetch PC.
// Assumes: act_i gives the pipeline action for this cycle. cidx_i is only
// meaningful on a catch, and pos_i and rpc_i only during a walk.
module cfr_slot_track
    import cfr_pkg::*;
#(
    parameter int             NSTG     = 5,
    parameter int             PCW      = 16,
    parameter int             IDW      = 3,
    parameter logic [PCW-1:0] STEP     = 'd4,
    parameter logic [PCW-1:0] RESET_PC = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  act_e                      act_i,
    input  logic [IDW-1:0]            cidx_i,
    input  logic [IDW-1:0]            pos_i,
    input  logic [PCW-1:0]            rpc_i,
    output logic [NSTG-1:0]           vld_o,
    output logic [NSTG-1:0][PCW-1:0]  pc_o,
    output logic [PCW-1:0]            fpc_o
);

    logic [NSTG-1:0]          vld_q, vld_d;
    logic [NSTG-1:0][PCW-1:0] pc_q,  pc_d;
    logic [PCW-1:0]           fpc_q, fpc_d;

    // Next stage contents for the chosen action
    always_comb begin
        vld_d = vld_q;
        pc_d  = pc_q;
        fpc_d = fpc_q;
        unique case (act_i)
            ACT_RUN: begin
                for (int j = 1; j < NSTG; j++) begin
                    vld_d[j] = vld_q[j-1];
                    pc_d[j]  = pc_q[j-1];
                end
                vld_d[0] = 1'b1;
                pc_d[0]  = fpc_q;
                fpc_d    = fpc_q + STEP;
            end
            ACT_CATCH: begin
                for (int j = 1; j < NSTG; j++) begin
                    if (j > int'(cidx_i) + 1) begin
                        vld_d[j] = vld_q[j-1];
                        pc_d[j]  = pc_q[j-1];
                    end else if (j == int'(cidx_i) + 1) begin
                        vld_d[j] = 1'b0;
                    end
                end
            end
            ACT_WALK: begin
                for (int j = 1; j < NSTG; j++) begin
                    if (j > int'(pos_i)) begin
                        vld_d[j] = vld_q[j-1];
                        pc_d[j]  = pc_q[j-1];
                    end else if (j == int'(pos_i) || j == int'(pos_i) - 1) begin
                        vld_d[j] = 1'b0;
                    end
                end
                if (int'(pos_i) <= 1) vld_d[0] = 1'b0;
                if (pos_i == '0)      fpc_d    = rpc_i;
            end
            default: ;
        endcase
    end

    // Stage and fetch registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            pc_q  <= '0;
            fpc_q <= RESET_PC;
        end else begin
            vld_q <= vld_d;
            pc_q  <= pc_d;
            fpc_q <= fpc_d;
        end
    end

    assign vld_o = vld_q;
    assign pc_o  = pc_q;
    assign fpc_o = fpc_q;

    // R2
    fetch_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_RUN) |=> (vld_q[0] && pc_q[0] == $past(fpc_q)));

    // R6
    fetch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_WALK && pos_i != '0) |=> (fpc_q == $past(fpc_q)));

    for (genvar g = 0; g < NSTG-1; g++) begin : g_stage_chk
        // R3
        bubble_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_i == ACT_CATCH && cidx_i == IDW'(g)) |=>
                (!vld_q[g+1] && vld_q[g] && pc_q[g] == $past(pc_q[g])));

        // R4
        bubble_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_i == ACT_RUN && !vld_q[g]) |=> !vld_q[g+1]);
    end

endmodule

// File: rtl/cf_recovery_ctrl.sv
// Top level of the counter-flow flush recovery controller.
// Assumes: err_i bit g flags stage register g. The register feeding the
// last stage (writeback) is a stabilizer stage with no error input.
module cf_recovery_ctrl
    import cfr_pkg::*;
#(
    parameter int             NSTG     = 5,
    parameter int             PCW      = 16,
    parameter logic [PCW-1:0] STEP     = 'd4,
    parameter logic [PCW-1:0] RESET_PC = 'h0100,
    localparam int            IDW      = $clog2(NSTG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTG-2:0] err_i,
    output logic [NSTG-1:0] stage_vld_o,
    output logic [NSTG-2:0] inject_o,
    output logic            flush_vld_o,
    output logic [IDW-1:0]  flush_id_o,
    output logic [IDW-1:0]  flush_pos_o,
    output logic            restart_o,
    output logic [PCW-1:0]  restart_pc_o,
    output logic [PCW-1:0]  fetch_pc_o,
    output logic            wb_vld_o,
    output logic [PCW-1:0]  wb_pc_o
);

    act_e                     act;
    logic                     hit;
    logic [IDW-1:0]           cidx;
    logic                     live;
    logic [IDW-1:0]           pos;
    logic [PCW-1:0]           rpc;
    logic [NSTG-1:0]          vld;
    logic [NSTG-1:0][PCW-1:0] pcs;

    cfr_fault_pick #(.NSTG(NSTG), .IDW(IDW)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .err_i  (err_i),
        .vld_i  (vld),
        .live_i (live),
        .pos_i  (pos),
        .hit_o  (hit),
        .idx_o  (cidx)
    );

    cfr_flush_train #(.NSTG(NSTG), .PCW(PCW), .IDW(IDW), .STEP(STEP)) u_train (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .cidx_i    (cidx),
        .fail_pc_i (pcs[cidx]),
        .act_o     (act),
        .live_o    (live),
        .pos_o     (pos),
        .fid_o     (flush_id_o),
        .rpc_o     (rpc),
        .inject_o  (inject_o),
        .restart_o (restart_o)
    );

    cfr_slot_track #(.NSTG(NSTG), .PCW(PCW), .IDW(IDW), .STEP(STEP),
                     .RESET_PC(RESET_PC)) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .cidx_i (cidx),
        .pos_i  (pos),
        .rpc_i  (rpc),
        .vld_o  (vld),
        .pc_o   (pcs),
        .fpc_o  (fetch_pc_o)
    );

    assign stage_vld_o  = vld;
    assign flush_vld_o  = live;
    assign flush_pos_o  = pos;
    assign restart_pc_o = rpc;
    assign wb_vld_o     = vld[NSTG-1];
    assign wb_pc_o      = pcs[NSTG-1];

endmodule

// File: tb/cf_recovery_ctrl_test.sv
`timescale 1ns/1ps
module cf_recovery_ctrl_test;

    localparam int          NSTG = 5;
    localparam int          PCW  = 16;
    localparam int          IDW  = 3;
    localparam logic [15:0] STEP = 16'd4;
    localparam logic [15:0] BOOT = 16'h0100;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSTG-2:0] err_i;
    logic [NSTG-1:0] stage_vld_o;
    logic [NSTG-2:0] inject_o;
    logic            flush_vld_o;
    logic [IDW-1:0]  flush_id_o;
    logic [IDW-1:0]  flush_pos_o;
    logic            restart_o;
    logic [PCW-1:0]  restart_pc_o;
    logic [PCW-1:0]  fetch_pc_o;
    logic            wb_vld_o;
    logic [PCW-1:0]  wb_pc_o;

    cf_recovery_ctrl #(.NSTG(NSTG), .PCW(PCW), .STEP(STEP), .RESET_PC(BOOT)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_i        (err_i),
        .stage_vld_o  (stage_vld_o),
        .inject_o     (inject_o),
        .flush_vld_o  (flush_vld_o),
        .flush_id_o   (flush_id_o),
        .flush_pos_o  (flush_pos_o),
        .restart_o    (restart_o),
        .restart_pc_o (restart_pc_o),
        .fetch_pc_o   (fetch_pc_o),
        .wb_vld_o     (wb_vld_o),
        .wb_pc_o      (wb_pc_o)
    );

    // 250 MHz clock
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    bit          m_vld [NSTG];
    logic [15:0] m_pc  [NSTG];
    bit          m_live;
    int          m_pos;
    int          m_fid;
    logic [15:0] m_rpc;
    logic [15:0] m_fpc;
    logic [3:0]  m_inj;

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic logic [NSTG-1:0] m_vldv();
        logic [NSTG-1:0] v;
        for (int j = 0; j < NSTG; j++) v[j] = m_vld[j];
        return v;
    endfunction

    task automatic model_reset();
        for (int j = 0; j < NSTG; j++) begin
            m_vld[j] = 1'b0;
            m_pc[j]  = '0;
        end
        m_live = 1'b0; m_pos = 0; m_fid = 0;
        m_rpc  = '0;   m_fpc = BOOT; m_inj = '0;
    endtask

    // One clock edge of the reference behaviour (R2..R10)
    task automatic model_edge(input logic [3:0] e);
        bit          hit = 1'b0;
        int          k   = 0;
        bit          nv [NSTG];
        logic [15:0] np [NSTG];
        logic [15:0] nf = m_fpc;
        for (int j = 0; j < NSTG-1; j++)
            if (e[j] && m_vld[j] && (!m_live || j >= m_pos)) begin hit = 1'b1; k = j; end
        for (int j = 0; j < NSTG; j++) begin nv[j] = m_vld[j]; np[j] = m_pc[j]; end
        if (hit) begin
            for (int j = k + 2; j < NSTG; j++) begin nv[j] = m_vld[j-1]; np[j] = m_pc[j-1]; end
            nv[k+1] = 1'b0;
            m_live = 1'b1; m_pos = k; m_fid = k;
            m_rpc  = m_pc[k] + STEP;
            m_inj  = 4'b0001 << k;
        end else if (m_live) begin
            m_inj = '0;
            for (int j = m_pos + 1; j < NSTG; j++) begin nv[j] = m_vld[j-1]; np[j] = m_pc[j-1]; end
            nv[m_pos] = 1'b0;
            if (m_pos > 0) begin
                nv[m_pos-1] = 1'b0;
                m_pos--;
            end else begin
                m_live = 1'b0;
                nf     = m_rpc;
            end
        end else begin
            m_inj = '0;
            for (int j = 1; j < NSTG; j++) begin nv[j] = m_vld[j-1]; np[j] = m_pc[j-1]; end
            nv[0] = 1'b1; np[0] = m_fpc;
            nf    = m_fpc + STEP;
        end
        for (int j = 0; j < NSTG; j++) begin m_vld[j] = nv[j]; m_pc[j] = np[j]; end
        m_fpc = nf;
    endtask

    task automatic compare_all();
        check("R4", "stage_vld", stage_vld_o, m_vldv());
        if (m_vld[NSTG-1]) check("R2", "wb_pc", wb_pc_o, m_pc[NSTG-1]);
        check("R3", "inject", inject_o, m_inj);
        check("R5", "flush_vld", flush_vld_o, m_live);
        if (m_live) begin
            check("R5", "flush_id", flush_id_o, m_fid);
            check("R5", "flush_pos", flush_pos_o, m_pos);
            check("R7", "restart_pc", restart_pc_o, m_rpc);
        end
        check("R7", "restart", restart_o, (m_live && m_pos == 0));
        check("R6", "fetch_pc", fetch_pc_o, m_fpc);
    endtask

    task automatic cycle(input logic [3:0] e);
        err_i = e;
        @(posedge clk);
        model_edge(e);
        @(negedge clk);
        compare_all();
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4177));
        rst_n = 1'b0;
        err_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        // R1 reset state
        check("R1", "stage_vld", stage_vld_o, '0);
        check("R1", "flush_vld", flush_vld_o, 1'b0);
        check("R1", "inject", inject_o, '0);
        check("R1", "fetch_pc", fetch_pc_o, BOOT);
        rst_n = 1'b1;

        // R9: error on an empty stage is ignored
        cycle(4'b1000);
        check("R9", "empty-stage flush_vld", flush_vld_o, 1'b0);
        repeat (5) cycle('0);
        // R2: full pipeline after six fetches
        check("R2", "stage_vld full", stage_vld_o, 5'h1f);
        check("R2", "wb_pc", wb_pc_o, 16'h0104);

        // Single catch at stage 2 (pc 0x10C)
        cycle(4'b0100);
        check("R3", "bubble behind", stage_vld_o[3], 1'b0);
        check("R3", "failing held", stage_vld_o[2], 1'b1);
        check("R3", "inject", inject_o, 4'b0100);
        check("R5", "flush_id", flush_id_o, 3'd2);
        check("R5", "flush_pos", flush_pos_o, 3'd2);
        check("R7", "restart_pc", restart_pc_o, 16'h0110);
        cycle('0);
        check("R5", "walk pos", flush_pos_o, 3'd1);
        check("R6", "younger cleared", stage_vld_o[1], 1'b0);
        check("R6", "fetch frozen", fetch_pc_o, 16'h0118);
        check("R3", "inject drop", inject_o, '0);
        cycle('0);
        check("R7", "restart at front", restart_o, 1'b1);
        cycle('0);
        check("R7", "token gone", flush_vld_o, 1'b0);
        check("R7", "fetch redirect", fetch_pc_o, 16'h0110);
        repeat (7) cycle('0);

        // R8: simultaneous errors, highest stage wins
        cycle(4'b1010);
        check("R8", "flush_id", flush_id_o, 3'd3);
        check("R8", "inject", inject_o, 4'b1000);
        cycle('0);
        // R9: error below the token is ignored
        cycle(4'b0001);
        check("R9", "frozen flush_pos", flush_pos_o, 3'd1);
        check("R9", "frozen flush_id", flush_id_o, 3'd3);
        check("R9", "frozen inject", inject_o, '0);
        repeat (8) cycle('0);

        // R10: new catch in the cycle the token sits at the front
        cycle(4'b0010);
        cycle('0);
        check("R10", "token at front", flush_pos_o, 3'd0);
        cycle(4'b0100);
        check("R10", "recatch id", flush_id_o, 3'd2);
        check("R10", "recatch pos", flush_pos_o, 3'd2);
        check("R10", "recatch live", flush_vld_o, 1'b1);
        repeat (6) cycle('0);

        // Random error bursts against the model
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] e;
            for (int b = 0; b < NSTG-1; b++) e[b] = ($urandom % 6) == 0;
            if (($urandom % 4) == 0) e = '0;
            cycle(e);
        end
        repeat (8) cycle('0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule